// File: doc/BRIEF.md
# Checkpointed Shadow Register File

This block is a general-purpose register file with two read ports and one write port that also supports atomic transactions. A transaction is opened with a begin strobe. At that clock edge the full architectural register state is copied into a second, speculative copy. Every write made while the transaction is open lands in the speculative copy only, and reads during the transaction return the speculative values. The architectural contents stay frozen.

A commit strobe makes the speculative copy the architectural state in a single clock edge. An abort strobe discards the speculative copy, so the architectural contents are exactly what they were when the transaction opened. Both copies are full register banks. Commit only flips the selector that marks which bank is architectural, so no data has to move at commit. Requests that make no sense in the current state raise a one-cycle error flag and change nothing. These are a begin while a transaction is open, a commit or abort while none is open, and more than one strobe in the same cycle.

Top module: `ckpt_regfile`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 on both read ports, `txn_busy` is 0 and `txn_err` is 0.
- R2: Register index 0 always reads 0 on both ports. A write to index 0 is ignored, inside or outside a transaction.
- R3: Outside a transaction, a write with `wr_en`=1 updates the architectural register at the clock edge. Reads are combinational, so the new value is visible right after that edge.
- R4: A valid begin copies the whole architectural state into the speculative copy at the clock edge. A write in the same cycle as the begin is part of both copies.
- R5: While a transaction is open, writes go only to the speculative copy and both read ports return speculative values.
- R6: A valid commit makes the speculative contents architectural at the clock edge. A write in the same cycle as the commit is included in the committed state.
- R7: A valid abort restores the view of the architectural state as it was at begin. A write in the same cycle as the abort is dropped.
- R8: `txn_busy` rises at the edge of a valid begin and falls at the edge of a valid commit or abort.
- R9: A begin while busy, a commit or abort while idle, or two or more strobes in one cycle sets `txn_err` for the one cycle after that edge and leaves `txn_busy` and the transaction state unchanged. A write in that cycle is handled as if no strobe had been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_addr | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| txn_begin | input | 1 | Open a transaction (strobe) |
| txn_commit | input | 1 | Commit the open transaction (strobe) |
| txn_abort | input | 1 | Abort the open transaction (strobe) |
| txn_busy | output | 1 | High while a transaction is open |
| txn_err | output | 1 | One-cycle flag for an illegal strobe request |

## Verification
The hardest situations to reach are strobe cycles that carry a write at the same time. A write alongside a begin must land in both banks. One alongside a commit must survive, and one alongside an abort must vanish. One alongside an illegal strobe must behave as a plain write to whichever copy is active. The vector table drives each of these combinations from the ports and then proves the outcome through later reads after the transaction closes. A directed pass fills all 31 writable registers inside a transaction and commits them, so a wrong bank flip shows up on every index. A second directed pass resets in mid-transaction.

// File: rtl/ckpt_pkg.sv
// Package: shared sizes and the transaction action code used by the
// controller and the register-file top.
package ckpt_pkg;

    localparam int unsigned CKPT_NREG  = 32;
    localparam int unsigned CKPT_WIDTH = 32;

    // Decoded strobe request for the current cycle.
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_BEGIN   = 3'd1,
        ACT_COMMIT  = 3'd2,
        ACT_ABORT   = 3'd3,
        ACT_ILLEGAL = 3'd4
    } txn_act_e;

endpackage

// File: rtl/ckpt_bank.sv
// Module: ckpt_bank
// One full copy of the register state. Entry 0 is a constant zero.
// A bulk load replaces every entry in one edge and wins over a single
// write. The caller merges any same-cycle write into the load image.
// Assumes the synchronous active-low reset clears all entries.
module ckpt_bank #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG),
    localparam int FLAT = NREG * WIDTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [FLAT-1:0] load_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [FLAT-1:0] contents
);

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        if (i == 0) begin : g_zero
            // Index 0 is hardwired to zero.
            assign contents[WIDTH-1:0] = '0;
        end else begin : g_reg
            logic [WIDTH-1:0] q;
            // Entry storage: reset, bulk load, or single write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (load_en) begin
                    q <= load_data[i*WIDTH +: WIDTH];
                end else if (wr_en && (wr_addr == AW'(i))) begin
                    q <= wr_data;
                end
            end
            assign contents[i*WIDTH +: WIDTH] = q;
        end
    end

endmodule

// File: rtl/ckpt_read_port.sv
// Module: ckpt_read_port
// Combinational read of one register out of a flattened bank image.
// Assumes index 0 must read zero regardless of the image.
module ckpt_read_port #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG),
    localparam int FLAT = NREG * WIDTH
) (
    input  logic [FLAT-1:0]  image,
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] data
);

    // Select the addressed slice, forcing zero for index 0.
    always_comb begin
        if (addr == '0) begin
            data = '0;
        end else begin
            data = image[addr*WIDTH +: WIDTH];
        end
    end

endmodule

// File: rtl/ckpt_txn_ctrl.sv
// Module: ckpt_txn_ctrl
// Decodes the begin/commit/abort strobes into one action per cycle and
// keeps the busy flag, the architectural-bank selector and the error flag.
// Assumes strobes are single-cycle requests sampled at the rising edge.
module ckpt_txn_ctrl
    import ckpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_open,
    input  logic     req_commit,
    input  logic     req_abort,
    output txn_act_e act,
    output logic     busy,
    output logic     arch_sel,
    output logic     err
);

    logic [1:0] n_req;

    // Classify this cycle's strobes into a single legal or illegal action.
    always_comb begin
        n_req = 2'($countones({req_open, req_commit, req_abort}));
        if (n_req == 2'd0) begin
            act = ACT_NONE;
        end else if (n_req != 2'd1) begin
            act = ACT_ILLEGAL;
        end else if (req_open) begin
            act = busy ? ACT_ILLEGAL : ACT_BEGIN;
        end else if (req_commit) begin
            act = busy ? ACT_COMMIT : ACT_ILLEGAL;
        end else begin
            act = busy ? ACT_ABORT : ACT_ILLEGAL;
        end
    end

    // Transaction state: busy flag, bank selector, one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            arch_sel <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= (act == ACT_ILLEGAL);
            case (act)
                ACT_BEGIN:  busy <= 1'b1;
                ACT_COMMIT: begin
                    busy     <= 1'b0;
                    arch_sel <= ~arch_sel;
                end
                ACT_ABORT:  busy <= 1'b0;
                default:    ;
            endcase
        end
    end

    AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ILLEGAL) |=> (busy == $past(busy) && arch_sel == $past(arch_sel))); // R9
    AST_ILLEGAL_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_open && busy) |=> err); // R9
    AST_COMMIT_SWAPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_commit && busy && !req_open && !req_abort) |=> (!busy && arch_sel != $past(arch_sel))); // R6
    AST_BEGIN_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_open && !busy && !req_commit && !req_abort) |=> (busy && !err)); // R8

endmodule

// File: rtl/ckpt_regfile.sv
// Module: ckpt_regfile
// Register file with two read ports, one write port and atomic
// transactions. Two banks are kept. arch_sel marks the architectural one,
// and the other holds the speculative copy while a transaction is open.
// Begin bulk-copies architectural into speculative, commit flips the
// selector, and abort leaves the selector alone.
// Assumes synchronous active-low reset.
module ckpt_regfile
    import ckpt_pkg::*;
#(
    parameter int NREG  = CKPT_NREG,
    parameter int WIDTH = CKPT_WIDTH,
    localparam int AW   = $clog2(NREG),
    localparam int FLAT = NREG * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_addr,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [AW-1:0]    rd_b_addr,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             txn_begin,
    input  logic             txn_commit,
    input  logic             txn_abort,
    output logic             txn_busy,
    output logic             txn_err
);

    txn_act_e        act;
    logic            arch_sel;
    logic            busy;
    logic [FLAT-1:0] bank_q [2];
    logic [FLAT-1:0] arch_img;
    logic [FLAT-1:0] spec_img;
    logic [FLAT-1:0] view_img;
    logic [FLAT-1:0] snap_img;
    logic            wr_ok;
    logic [AW-1:0]   rd_addr [2];
    logic [WIDTH-1:0] rd_data [2];

    ckpt_txn_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_open   (txn_begin),
        .req_commit (txn_commit),
        .req_abort  (txn_abort),
        .act        (act),
        .busy       (busy),
        .arch_sel   (arch_sel),
        .err        (txn_err)
    );

    assign txn_busy = busy;
    assign wr_ok    = wr_en && (wr_addr != '0);
    assign arch_img = bank_q[arch_sel];
    assign spec_img = bank_q[~arch_sel];
    assign view_img = busy ? spec_img : arch_img;

    // Snapshot image: architectural state with any same-cycle write merged.
    always_comb begin
        snap_img = arch_img;
        if (wr_ok) begin
            snap_img[wr_addr*WIDTH +: WIDTH] = wr_data;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_arch;
        logic bank_wr;
        logic bank_load;
        assign is_arch   = (arch_sel == 1'(b));
        // Architectural bank takes writes only when idle. The speculative
        // bank takes them while busy, except in an abort cycle.
        assign bank_wr   = wr_ok && (is_arch ? !busy : (busy && act != ACT_ABORT));
        assign bank_load = (act == ACT_BEGIN) && !is_arch;

        ckpt_bank #(.NREG(NREG), .WIDTH(WIDTH)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (bank_load),
            .load_data (snap_img),
            .wr_en     (bank_wr),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .contents  (bank_q[b])
        );
    end

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        ckpt_read_port #(.NREG(NREG), .WIDTH(WIDTH)) i_rd (
            .image (view_img),
            .addr  (rd_addr[p]),
            .data  (rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    AST_SNAPSHOT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_BEGIN) |=> (spec_img == arch_img)); // R4
    AST_ARCH_FROZEN_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && act != ACT_COMMIT) |=> (arch_img == $past(arch_img))); // R7
    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0)); // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0)); // R2

endmodule

// File: tb/test_ckpt_regfile.sv
// Bench for ckpt_regfile: a vector table walked by one loop, then directed
// reset and corner-case tests.
module test_ckpt_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, txn_begin, txn_commit, txn_abort, txn_busy, txn_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ckpt_regfile i_ckpt_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
        .txn_busy(txn_busy), .txn_err(txn_err)
    );

    // Fields: [79:77] begin,commit,abort [76] we [75:71] waddr [70:39] wdata
    //         [38:34] raddr [33:2] expected read [1] busy [0] err
    localparam int NV = 19;
    localparam logic [79:0] VEC [NV] = '{
        {3'b000,1'b1,5'd5, 32'h11111111,5'd5, 32'h11111111,1'b0,1'b0}, // R3
        {3'b000,1'b1,5'd0, 32'h0000DEAD,5'd0, 32'h00000000,1'b0,1'b0}, // R2
        {3'b100,1'b1,5'd6, 32'h00000066,5'd6, 32'h00000066,1'b1,1'b0}, // R4 R8
        {3'b000,1'b1,5'd5, 32'h00000055,5'd5, 32'h00000055,1'b1,1'b0}, // R5
        {3'b000,1'b1,5'd0, 32'h00000001,5'd0, 32'h00000000,1'b1,1'b0}, // R2
        {3'b001,1'b1,5'd7, 32'h00000077,5'd7, 32'h00000000,1'b0,1'b0}, // R7
        {3'b000,1'b0,5'd0, 32'h00000000,5'd5, 32'h11111111,1'b0,1'b0}, // R7
        {3'b000,1'b0,5'd0, 32'h00000000,5'd6, 32'h00000066,1'b0,1'b0}, // R4
        {3'b100,1'b0,5'd0, 32'h00000000,5'd5, 32'h11111111,1'b1,1'b0}, // R4
        {3'b000,1'b1,5'd5, 32'h0000ABCD,5'd5, 32'h0000ABCD,1'b1,1'b0}, // R5
        {3'b010,1'b1,5'd8, 32'h00000088,5'd8, 32'h00000088,1'b0,1'b0}, // R6
        {3'b000,1'b0,5'd0, 32'h00000000,5'd5, 32'h0000ABCD,1'b0,1'b0}, // R6
        {3'b010,1'b1,5'd9, 32'h00000099,5'd9, 32'h00000099,1'b0,1'b1}, // R9
        {3'b000,1'b0,5'd0, 32'h00000000,5'd9, 32'h00000099,1'b0,1'b0}, // R9
        {3'b100,1'b0,5'd0, 32'h00000000,5'd9, 32'h00000099,1'b1,1'b0}, // R8
        {3'b100,1'b1,5'd10,32'h0000000A,5'd10,32'h0000000A,1'b1,1'b1}, // R9
        {3'b110,1'b0,5'd0, 32'h00000000,5'd10,32'h0000000A,1'b1,1'b1}, // R9
        {3'b001,1'b0,5'd0, 32'h00000000,5'd10,32'h00000000,1'b0,1'b0}, // R7
        {3'b001,1'b0,5'd0, 32'h00000000,5'd5, 32'h0000ABCD,1'b0,1'b1}  // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        txn_begin = 1'b0; txn_commit = 1'b0; txn_abort = 1'b0;
    endtask

    // Drive at the falling edge, let one rising edge pass, clear strobes.
    task automatic step(input logic b, input logic c, input logic a,
                        input logic we, input logic [4:0] wa, input logic [31:0] wd);
        @(negedge clk);
        txn_begin = b; txn_commit = c; txn_abort = a;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        rd_a_addr = '0; rd_b_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state: R1
        for (int i = 0; i < 32; i += 7) begin
            rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
            #1;
            chk("R1 port A", rd_a_data, 32'h0);
            chk("R1 port B", rd_b_data, 32'h0);
        end
        chk("R1 busy", {31'h0, txn_busy}, 32'h0);
        chk("R1 err",  {31'h0, txn_err},  32'h0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            rd_a_addr = VEC[v][38:34];
            rd_b_addr = VEC[v][38:34];
            step(VEC[v][79], VEC[v][78], VEC[v][77], VEC[v][76], VEC[v][75:71], VEC[v][70:39]);
            chk($sformatf("vec %0d port A (R2-R9 table)", v), rd_a_data, VEC[v][33:2]);
            chk($sformatf("vec %0d port B (R2-R9 table)", v), rd_b_data, VEC[v][33:2]);
            chk($sformatf("vec %0d busy R8", v), {31'h0, txn_busy}, {31'h0, VEC[v][1]});
            chk($sformatf("vec %0d err R9", v),  {31'h0, txn_err},  {31'h0, VEC[v][0]});
        end

        // Directed: fill every writable register inside a transaction, commit.
        step(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
        for (int i = 1; i < 32; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 5'(i), 32'hC0DE0000 + 32'(i));
        end
        step(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
        chk("R6 busy after commit", {31'h0, txn_busy}, 32'h0);
        for (int i = 1; i < 32; i++) begin
            rd_a_addr = 5'(i); rd_b_addr = 5'(32 - i);
            #1;
            chk("R6 fill port A", rd_a_data, 32'hC0DE0000 + 32'(i));
            chk("R6 fill port B", rd_b_data, 32'hC0DE0000 + 32'(32 - i));
        end

        // Directed: abort after overwriting everything brings back the old values.
        step(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
        for (int i = 1; i < 32; i += 5) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 5'(i), 32'hFFFF0000);
        end
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0);
        for (int i = 1; i < 32; i += 5) begin
            rd_a_addr = 5'(i);
            #1;
            chk("R7 restore after abort", rd_a_data, 32'hC0DE0000 + 32'(i));
        end

        // Directed: reset in the middle of a transaction.
        step(1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 32'h33333333);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        rd_a_addr = 5'd3; rd_b_addr = 5'd31;
        #1;
        chk("R1 busy after mid-txn reset", {31'h0, txn_busy}, 32'h0);
        chk("R1 reg3 after reset", rd_a_data, 32'h0);
        chk("R1 reg31 after reset", rd_b_data, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule